// File: doc/BRIEF.md
# Complementary Motor-Control PWM Generator

This block drives the six switch gates of a three-phase bridge from one programmable counter. In complementary mode each phase leg is a top/bottom pair. A programmable dead band keeps both switches of a leg off for a while after every change of state. In independent mode the six outputs are separate PWM channels, each with its own duty value. The counter runs edge-aligned, counting up and wrapping, or center-aligned, counting up and then back down. An output is active while the counter is below its duty value.

Software writes period and duty values into buffer registers through a simple write port. They move into the active registers only at a reload point, which comes once every N full periods (N from 1 to 16). In center-aligned mode a reload can also come at every half period. Each reload raises a one-cycle sync pulse, suitable for starting an ADC conversion, and sets a sticky interrupt flag. A fault input forces every output to its inactive level at once. A latched fault is released at a period boundary, or only by software when manual release is selected. The mode, polarity and dead-time settings can be written once after reset.

Top module: `pwmc_top`

## Requirements
- R1: After reset every output sits at its inactive level, which is low with polarity not inverted. irq_o and sync_o are low, the counter is stopped, and all registers are zero.
- R2: In complementary mode (address 1 bit 0 = 0), the top output of pair p (pwm_o[2p]) follows "counter below duty register 3+2p", and the bottom output (pwm_o[2p+1]) follows its inverse. After each change of that level both outputs stay inactive for DT cycles, where DT is taken from address 1 bits 8 and up. The two outputs of a pair are never active together.
- R3: In independent mode (address 1 bit 0 = 1), output i follows "counter below duty register 3+i" with no dead band.
- R4: In edge-aligned mode (address 0 bit 1 = 0) the counter runs 0 up to M-1, so a period lasts M cycles. M is the modulus at address 2, and values below 2 act as 2. An output with duty D is active for min(D, M) cycles per period, so D=0 gives 0% and D>=M gives 100%.
- R5: In center-aligned mode (address 0 bit 1 = 1) the counter runs 0 up to M-1, holds there for one cycle, counts down to 0, and holds there for one cycle. A period lasts 2M cycles, and the active time per period is 2*min(D, M) cycles.
- R6: Writes to addresses 2 to 8 go to buffer registers. While running (address 0 bit 0 = 1), the active registers change only at a reload point. While stopped, they follow the buffers.
- R7: With address 0 bits 11:8 = K, a reload happens at the end of every (K+1)-th full period. Each reload gives a one-cycle high on sync_o in the first cycle of the new period and sets irq_o. irq_o stays set until a control write with bit 4 = 1, and a reload in the same cycle takes precedence over that clear.
- R8: Address 0 bit 12 selects a reload at every half period, but only in center-aligned mode. In edge-aligned mode this bit has no effect.
- R9: While fault_i is high, all outputs are at their inactive level in the same cycle. The fault is latched. With address 0 bit 2 = 0, the latch is released at the first period end after fault_i goes low.
- R10: With address 0 bit 2 = 1, a latched fault is released only by a control write with bit 3 = 1 while fault_i is low.
- R11: The first write to address 1 after reset is accepted, and every later write to address 1 is ignored until the next reset.
- R12: Address 1 bit 1 inverts all top outputs and bit 2 inverts all bottom outputs. The inactive level of an output is its inversion bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | 16 | Register write data |
| fault_i | input | 1 | Fault input, active high |
| pwm_o | output | 6 | Gate outputs; even bits top, odd bits bottom of each pair |
| irq_o | output | 1 | Sticky reload interrupt flag |
| sync_o | output | 1 | One-cycle pulse at each reload |

## Verification
The assertions watch properties that must hold in every cycle:
- the two outputs of a complementary pair are never active together;
- a high fault input always produces the inactive pattern;
- sync pulses last one cycle and always come with the flag set;
- locked settings never move;
- the active modulus changes only at a reload while running.

The bench scenarios show what a single cycle cannot:
- the active-cycle counts per period for each alignment, duty extreme and dead time;
- the spacing of reloads for a given N and in half-period mode;
- the point at which a buffered duty first takes effect;
- the way a latched fault is released in the automatic and manual modes.

// File: rtl/pwmc_pkg.sv
package pwmc_pkg;
    localparam int ADDR_W = 4;

    localparam logic [ADDR_W-1:0] A_CTRL  = 4'd0;
    localparam logic [ADDR_W-1:0] A_PROT  = 4'd1;
    localparam logic [ADDR_W-1:0] A_MOD   = 4'd2;
    localparam logic [ADDR_W-1:0] A_DUTY0 = 4'd3;

    localparam int B_RUN    = 0;
    localparam int B_CENTER = 1;
    localparam int B_MANCLR = 2;
    localparam int B_FCLR   = 3;
    localparam int B_ICLR   = 4;
    localparam int B_RLN_LO = 8;
    localparam int B_HALF   = 12;

    localparam int B_INDEP  = 0;
    localparam int B_TINV   = 1;
    localparam int B_BINV   = 2;
    localparam int B_DT_LO  = 8;

    typedef struct packed {
        logic       run;
        logic       center;
        logic       man_clr;
        logic       half;
        logic [3:0] rl_n;
    } ctrl_t;

    typedef struct packed {
        logic indep;
        logic top_inv;
        logic bot_inv;
    } mode_t;
endpackage

// File: rtl/pwmc_timebase.sv
module pwmc_timebase #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             center,
    input  logic [CNT_W-1:0] eff,
    output logic [CNT_W-1:0] cnt_o,
    output logic             full_o,
    output logic             half_o
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             down;
    } tb_t;

    tb_t              q, d;
    logic [CNT_W-1:0] top;

    always_comb begin
        d      = q;
        full_o = 1'b0;
        half_o = 1'b0;
        top    = eff - ONE;
        if (!run) begin
            d.cnt  = '0;
            d.down = 1'b0;
        end else if (!center) begin
            d.down = 1'b0;
            if (q.cnt >= top) begin
                d.cnt  = '0;
                full_o = 1'b1;
            end else begin
                d.cnt = q.cnt + ONE;
            end
        end else if (!q.down) begin
            if (q.cnt >= top) begin
                d.cnt  = top;
                d.down = 1'b1;
                half_o = 1'b1;
            end else begin
                d.cnt = q.cnt + ONE;
            end
        end else begin
            if (q.cnt == '0) begin
                d.down = 1'b0;
                full_o = 1'b1;
            end else begin
                d.cnt = q.cnt - ONE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign cnt_o = q.cnt;
endmodule

// File: rtl/pwmc_reload.sv
module pwmc_reload (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic       center,
    input  logic       half_en,
    input  logic [3:0] rl_n,
    input  logic       full,
    input  logic       half,
    output logic       reload_o
);
    typedef struct packed {
        logic [3:0] seen;
    } rl_t;

    rl_t  q, d;
    logic use_half;
    logic tick;

    always_comb begin
        d        = q;
        use_half = center & half_en;
        tick     = full | (use_half & half);
        reload_o = run & tick & (use_half | (q.seen == rl_n));
        if (!run)          d.seen = '0;
        else if (reload_o) d.seen = '0;
        else if (tick)     d.seen = q.seen + 4'd1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/pwmc_pair.sv
module pwmc_pair #(
    parameter int DT_W = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            indep,
    input  logic [DT_W-1:0] dt,
    input  logic            lvl_top,
    input  logic            lvl_bot,
    output logic            top_o,
    output logic            bot_o
);
    typedef struct packed {
        logic            last;
        logic [DT_W-1:0] gap;
        logic            it;
        logic            ib;
    } pr_t;

    pr_t q, d;

    always_comb begin
        d    = q;
        d.it = lvl_top;
        d.ib = lvl_bot;
        if (lvl_top != q.last) begin
            d.last = lvl_top;
            d.gap  = dt;
        end else if (q.gap != '0) begin
            d.gap = q.gap - DT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign top_o = indep ? q.it : ((q.gap == '0) &  q.last);
    assign bot_o = indep ? q.ib : ((q.gap == '0) & ~q.last);
endmodule

// File: rtl/pwmc_top.sv
module pwmc_top
    import pwmc_pkg::*;
#(
    parameter int NPAIR  = 3,
    parameter int CNT_W  = 12,
    parameter int DT_W   = 6,
    parameter int DATA_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [DATA_W-1:0]   wr_data,
    input  logic                fault_i,
    output logic [2*NPAIR-1:0]  pwm_o,
    output logic                irq_o,
    output logic                sync_o
);
    localparam int               NOUT    = 2 * NPAIR;
    localparam logic [CNT_W-1:0] MIN_MOD = CNT_W'(2);

    typedef struct packed {
        ctrl_t                       ctrl;
        mode_t                       mode;
        logic [DT_W-1:0]             dt;
        logic                        locked;
        logic [CNT_W-1:0]            mod_buf;
        logic [CNT_W-1:0]            mod_act;
        logic [NOUT-1:0][CNT_W-1:0]  duty_buf;
        logic [NOUT-1:0][CNT_W-1:0]  duty_act;
        logic                        flt;
        logic                        irq;
        logic                        sync;
    } st_t;

    st_t              q, d;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] mod_eff;
    logic             full, half, reload, fclr, gate;
    logic [NOUT-1:0]  lvl;
    logic [NPAIR-1:0] top_raw, bot_raw;

    logic                  run_w, indep_w, tinv_w, binv_w, locked_w;
    logic [DT_W+2:0]       prot_w;
    logic [CNT_W-1:0]      modact_w;

    assign run_w    = q.ctrl.run;
    assign indep_w  = q.mode.indep;
    assign tinv_w   = q.mode.top_inv;
    assign binv_w   = q.mode.bot_inv;
    assign locked_w = q.locked;
    assign prot_w   = {q.mode, q.dt};
    assign modact_w = q.mod_act;
    assign mod_eff  = (q.mod_act < MIN_MOD) ? MIN_MOD : q.mod_act;

    pwmc_timebase #(.CNT_W(CNT_W)) tb_i (
        .clk(clk), .rst_n(rst_n), .run(q.ctrl.run), .center(q.ctrl.center),
        .eff(mod_eff), .cnt_o(cnt), .full_o(full), .half_o(half)
    );

    pwmc_reload rl_i (
        .clk(clk), .rst_n(rst_n), .run(q.ctrl.run), .center(q.ctrl.center),
        .half_en(q.ctrl.half), .rl_n(q.ctrl.rl_n), .full(full), .half(half),
        .reload_o(reload)
    );

    for (genvar i = 0; i < NOUT; i++) begin : g_lvl
        assign lvl[i] = (cnt < q.duty_act[i]);
    end

    for (genvar p = 0; p < NPAIR; p++) begin : g_pair
        pwmc_pair #(.DT_W(DT_W)) pair_i (
            .clk(clk), .rst_n(rst_n), .indep(q.mode.indep), .dt(q.dt),
            .lvl_top(lvl[2*p]), .lvl_bot(lvl[2*p+1]),
            .top_o(top_raw[p]), .bot_o(bot_raw[p])
        );
        assign pwm_o[2*p]   = (gate & top_raw[p]) ^ q.mode.top_inv;
        assign pwm_o[2*p+1] = (gate & bot_raw[p]) ^ q.mode.bot_inv;
    end

    assign gate = q.ctrl.run & ~q.flt & ~fault_i;

    always_comb begin
        d    = q;
        fclr = 1'b0;
        if (wr_en) begin
            if (wr_addr == A_CTRL) begin
                d.ctrl.run     = wr_data[B_RUN];
                d.ctrl.center  = wr_data[B_CENTER];
                d.ctrl.man_clr = wr_data[B_MANCLR];
                d.ctrl.half    = wr_data[B_HALF];
                d.ctrl.rl_n    = wr_data[B_RLN_LO +: 4];
                fclr           = wr_data[B_FCLR];
                if (wr_data[B_ICLR]) d.irq = 1'b0;
            end
            if (wr_addr == A_PROT && !q.locked) begin
                d.mode.indep   = wr_data[B_INDEP];
                d.mode.top_inv = wr_data[B_TINV];
                d.mode.bot_inv = wr_data[B_BINV];
                d.dt           = wr_data[B_DT_LO +: DT_W];
                d.locked       = 1'b1;
            end
            if (wr_addr == A_MOD) d.mod_buf = wr_data[CNT_W-1:0];
            for (int i = 0; i < NOUT; i++) begin
                if (wr_addr == ADDR_W'(int'(A_DUTY0) + i)) d.duty_buf[i] = wr_data[CNT_W-1:0];
            end
        end
        if (!q.ctrl.run || reload) begin
            d.mod_act  = q.mod_buf;
            d.duty_act = q.duty_buf;
        end
        d.sync = reload;
        if (reload) d.irq = 1'b1;
        if (fault_i) begin
            d.flt = 1'b1;
        end else if (q.flt && (q.ctrl.man_clr ? fclr : (full || !q.ctrl.run))) begin
            d.flt = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign irq_o  = q.irq;
    assign sync_o = q.sync;
endmodule

// File: rtl/pwmc_checker.sv
module pwmc_checker #(
    parameter int NPAIR = 3,
    parameter int CNT_W = 12,
    parameter int DT_W  = 6
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 fault_i,
    input logic [2*NPAIR-1:0]   pwm_o,
    input logic                 indep,
    input logic                 top_inv,
    input logic                 bot_inv,
    input logic                 locked,
    input logic [DT_W+2:0]      prot,
    input logic                 sync_o,
    input logic                 irq_o,
    input logic                 run,
    input logic                 reload,
    input logic [CNT_W-1:0]     mod_act
);
    logic [2*NPAIR-1:0] idle;

    for (genvar p = 0; p < NPAIR; p++) begin : g_chk
        assign idle[2*p]   = top_inv;
        assign idle[2*p+1] = bot_inv;

        p_pair_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
            !indep |-> !((pwm_o[2*p] ^ top_inv) && (pwm_o[2*p+1] ^ bot_inv)));
    end

    p_fault_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        fault_i |-> (pwm_o == idle));

    p_sync_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sync_o |=> !sync_o);

    p_irq_on_sync_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sync_o |-> irq_o);

    p_lock_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> $stable(prot));

    p_buffer_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !reload) |=> $stable(mod_act));
endmodule

bind pwmc_top pwmc_checker #(.NPAIR(NPAIR), .CNT_W(CNT_W), .DT_W(DT_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .fault_i(fault_i), .pwm_o(pwm_o),
    .indep(indep_w), .top_inv(tinv_w), .bot_inv(binv_w), .locked(locked_w),
    .prot(prot_w), .sync_o(sync_o), .irq_o(irq_o), .run(run_w),
    .reload(reload), .mod_act(modact_w)
);

// File: tb/pwmc_top_tb_top.sv
module pwmc_top_tb_top;
    import pwmc_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        fault_i = 1'b0;
    logic [5:0]  pwm_o;
    logic        irq_o, sync_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    int cnt_hi [6];
    int overlap;

    always #5 clk = ~clk;

    pwmc_top dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .fault_i(fault_i), .pwm_o(pwm_o),
        .irq_o(irq_o), .sync_o(sync_o)
    );

    typedef struct packed {
        int center; int indep; int dt; int modv; int da; int db;
        int period; int ea; int eb;
    } vec_t;

    localparam vec_t TBL [9] = '{
        '{0, 0, 0, 10,  3,  3, 10,  3,  7},
        '{0, 0, 2, 10,  4,  4, 10,  2,  4},
        '{1, 0, 1,  8,  3,  3, 16,  5,  9},
        '{0, 0, 0, 10,  0,  0, 10,  0, 10},
        '{0, 0, 0, 10, 10, 10, 10, 10,  0},
        '{1, 0, 0,  8, 20, 20, 16, 16,  0},
        '{0, 1, 3, 12,  5,  9, 12,  5,  9},
        '{1, 1, 0,  6,  2,  6, 12,  4, 12},
        '{0, 0, 1,  1,  1,  1,  2,  0,  0}
    };

    function automatic int ctrlv(int run, int center, int man, int fclr, int iclr, int rl, int half);
        return run | (center << 1) | (man << 2) | (fclr << 3) | (iclr << 4) | (rl << 8) | (half << 12);
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input int v);
        wr_en   = 1'b1;
        wr_addr = 4'(a);
        wr_data = 16'(v);
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic do_reset();
        rst_n   = 1'b0;
        fault_i = 1'b0;
        wr_en   = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic count_win(input int n);
        for (int i = 0; i < 6; i++) cnt_hi[i] = 0;
        overlap = 0;
        repeat (n) begin
            @(negedge clk);
            for (int i = 0; i < 6; i++) cnt_hi[i] += int'(pwm_o[i]);
            for (int p = 0; p < 3; p++) if (pwm_o[2*p] && pwm_o[2*p+1]) overlap++;
        end
    endtask

    task automatic wait_sync(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!sync_o && n < 300);
    endtask

    task automatic count_busy(input int n, output int c);
        c = 0;
        repeat (n) begin
            @(negedge clk);
            if (pwm_o != 6'b0) c++;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog R1 actual=timeout expected=completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int n;
        int bad;
        string req;

        do_reset();
        chk("R1 outputs idle after reset", int'(pwm_o), 0);
        chk("R1 irq low after reset", int'(irq_o), 0);
        chk("R1 sync low after reset", int'(sync_o), 0);

        for (int k = 0; k < 9; k++) begin
            do_reset();
            wr(A_PROT, TBL[k].indep | (TBL[k].dt << 8));
            wr(A_MOD, TBL[k].modv);
            for (int i = 0; i < 6; i++) wr(int'(A_DUTY0) + i, (i % 2 == 1) ? TBL[k].db : TBL[k].da);
            wr(A_CTRL, ctrlv(1, TBL[k].center, 0, 0, 0, 0, 0));
            repeat (3 * TBL[k].period + 4) @(negedge clk);
            count_win(TBL[k].period);
            if (TBL[k].indep != 0) req = $sformatf("R3 independent vec%0d", k);
            else if (TBL[k].center != 0) req = $sformatf("R5 center R2 pair vec%0d", k);
            else req = $sformatf("R4 edge R2 pair vec%0d", k);
            for (int i = 0; i < 6; i++)
                chk($sformatf("%s out%0d", req, i), cnt_hi[i], (i % 2 == 1) ? TBL[k].eb : TBL[k].ea);
            if (TBL[k].indep == 0) chk($sformatf("R2 no overlap vec%0d", k), overlap, 0);
        end

        do_reset();
        wr(A_PROT, 1 << 1);
        repeat (2) @(negedge clk);
        chk("R12 top inverted idle pattern", int'(pwm_o), 6'b010101);
        wr(A_PROT, 1 << 2);
        repeat (2) @(negedge clk);
        chk("R11 second protected write ignored", int'(pwm_o), 6'b010101);

        do_reset();
        wr(A_PROT, 0);
        wr(A_MOD, 10);
        wr(A_DUTY0, 3);
        wr(A_CTRL, ctrlv(1, 0, 0, 0, 0, 3, 0));
        wait_sync(n);
        wait_sync(n);
        chk("R7 reload every 4 periods", n, 40);
        wr(A_DUTY0, 7);
        chk("R7 sync lasts one cycle", int'(sync_o), 0);
        count_win(10);
        chk("R6 buffered duty not used before reload", cnt_hi[0], 3);
        wait_sync(n);
        count_win(10);
        chk("R6 buffered duty used after reload", cnt_hi[0], 7);
        chk("R7 irq set by reload", int'(irq_o), 1);
        wr(A_CTRL, ctrlv(1, 0, 0, 0, 1, 3, 0));
        chk("R7 irq cleared by control write", int'(irq_o), 0);

        do_reset();
        wr(A_PROT, 0);
        wr(A_MOD, 8);
        wr(A_CTRL, ctrlv(1, 1, 0, 0, 0, 0, 1));
        wait_sync(n);
        wait_sync(n);
        chk("R8 half-period reload in center mode", n, 8);
        wr(A_CTRL, ctrlv(0, 0, 0, 0, 0, 0, 0));
        wr(A_MOD, 10);
        wr(A_CTRL, ctrlv(1, 0, 0, 0, 0, 0, 1));
        wait_sync(n);
        wait_sync(n);
        chk("R8 half bit ignored in edge mode", n, 10);

        do_reset();
        wr(A_PROT, 0);
        wr(A_MOD, 10);
        wr(A_DUTY0, 5);
        wr(A_CTRL, ctrlv(1, 0, 0, 0, 0, 0, 0));
        repeat (30) @(negedge clk);
        fault_i = 1'b1;
        #1;
        chk("R9 fault idles outputs at once", int'(pwm_o), 0);
        count_busy(15, bad);
        chk("R9 outputs idle while fault held", bad, 0);
        wait_sync(n);
        fault_i = 1'b0;
        @(negedge clk);
        chk("R9 fault latched until period end", int'(pwm_o), 0);
        repeat (12) @(negedge clk);
        count_win(10);
        chk("R9 automatic recovery", cnt_hi[0], 5);

        wr(A_CTRL, ctrlv(1, 0, 1, 0, 0, 0, 0));
        repeat (5) @(negedge clk);
        fault_i = 1'b1;
        repeat (3) @(negedge clk);
        fault_i = 1'b0;
        repeat (10) @(negedge clk);
        count_busy(30, bad);
        chk("R10 manual mode holds fault off", bad, 0);
        wr(A_CTRL, ctrlv(1, 0, 1, 1, 0, 0, 0));
        repeat (12) @(negedge clk);
        count_win(10);
        chk("R10 recovery after clear strobe", cnt_hi[0], 5);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule